// File: doc/BRIEF.md
# MDIO Management Slave Register Block

This block is a clause 22 management slave. It oversamples the MDC clock and the MDIO data line with the local system clock, recognises management frames addressed to its configurable port address, and serves 32 register addresses of 16 bits each. Every address has two distinct registers. The input register is loaded by MDIO write frames and the local logic can only read it. The output register is loaded by the local logic and is returned to the station on MDIO read frames.

Three sticky event flags tell the local side that a register write finished, that a register read finished, or that a malformed frame was seen. The local side clears each flag with its own clear bit. It also gives each flag its own enable bit, and a single interrupt output is raised from the enabled flags. The frame is: at least 32 ones of preamble, start bits `01`, a 2-bit opcode (`01` write, `10` read), a 5-bit port address, a 5-bit register address, two turnaround bits, and 16 data bits. Every field is sent most significant bit first. The slave samples MDIO on rising MDC edges.

Top module: `mdio_slave_regs`

## Requirements
- R1: After reset all event flags are 0, `irq` is 0, `mdio_oe` is 0, and every input register reads 0 on the local read port.
- R2: A write frame (opcode `01`, turnaround `10`) whose port address equals `port_addr` stores its 16 data bits, sent MSB first, into the input register named by the register address. `loc_rdata` then shows that value for that `loc_raddr`. No other input register changes.
- R3: On a matched read frame (opcode `10`), the slave leaves MDIO undriven during the first turnaround bit and drives 0 during the second. It then drives the 16 bits of the addressed output register, MSB first, one bit per MDC period. The output register is loaded through `loc_we`/`loc_waddr`/`loc_wdata`.
- R4: The port address is taken from `port_addr` and may be changed between frames. A frame whose port address differs from it changes no register, never drives MDIO, and raises no event, even when its opcode is invalid.
- R5: A completed matched write sets `evt_flags[0]`.
- R6: A matched read sets `evt_flags[1]` after its last data bit.
- R7: The slave sets `evt_flags[2]` and discards the frame, with no register change, in three cases: start bits other than `01`, a matched frame whose opcode is `00` or `11`, and a matched write whose turnaround is not `10`.
- R8: Each event flag stays set until a cycle in which its bit of `evt_clr` is 1. Clearing one flag leaves the others as they are.
- R9: `irq` is 1 exactly when some flag is set whose bit of `evt_en` is 1.
- R10: A frame preceded by fewer than 32 consecutive ones is ignored: no register change, no MDIO drive and no event.
- R11: `mdio_oe` is 0 at all times other than the turnaround and data bits of a matched read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to oversample MDC and MDIO |
| rst | input | 1 | Synchronous active-high reset |
| mdc_i | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Data value driven by the slave |
| mdio_oe | output | 1 | Output enable for the MDIO pad driver |
| port_addr | input | 5 | Port address this slave answers to |
| loc_we | input | 1 | Local write strobe for the output register bank |
| loc_waddr | input | 5 | Output register selected for a local write |
| loc_wdata | input | 16 | Value for a local write |
| loc_raddr | input | 5 | Input register selected for local reading |
| loc_rdata | output | 16 | Contents of the selected input register |
| evt_en | input | 3 | Interrupt enables per flag (bit0 write, bit1 read, bit2 error) |
| evt_clr | input | 3 | Clear bits per flag, same bit order |
| evt_flags | output | 3 | Sticky event flags, same bit order |
| irq | output | 1 | Interrupt from enabled, set flags |

## Verification
The assertions assume that MDC is slow next to `clk`: each MDC half period lasts longer than the synchronizer depth plus one cycle. They also assume that MDIO changes only away from the rising MDC edge, and that the station releases the line during the turnaround and data bits of a read. The stimulus keeps to these conditions. MDC half periods last six system clocks, the bench model changes the data line only together with the falling MDC edge, and a pull-up model makes a released line read as 1. Before the frames that must be rejected, the bench places a 0 bit so that idle ones left over from the previous frame do not count toward the preamble.

// File: rtl/mdio_slave_pkg.sv
`timescale 1ns/1ps
package mdio_slave_pkg;

    localparam int PHY_AW    = 5;
    localparam int REG_AW    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int NUM_EVT   = 3;
    localparam int ADDR_BITS = PHY_AW + REG_AW;

    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_OPC,
        ST_ADDR,
        ST_TA1,
        ST_TA2,
        ST_DATA
    } frame_state_t;

    // one-cycle event pulses, wr is the least significant bit
    typedef struct packed {
        logic err;
        logic rd;
        logic wr;
    } evt_t;

    typedef struct packed {
        logic              we;
        logic [REG_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } bank_wr_t;

    function automatic logic opc_valid(input logic [1:0] opc);
        return (opc == OPC_WRITE) || (opc == OPC_READ);
    endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
`timescale 1ns/1ps
module mdio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic bit_stb,
    output logic bit_val
);

    logic [STAGES-1:0] mdc_sr;
    logic [STAGES-1:0] mdio_sr;
    logic              mdc_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_sr   <= '0;
            mdio_sr  <= '1;
            mdc_last <= 1'b0;
        end else begin
            mdc_sr   <= {mdc_sr[STAGES-2:0], mdc_i};
            mdio_sr  <= {mdio_sr[STAGES-2:0], mdio_i};
            mdc_last <= mdc_sr[STAGES-1];
        end
    end

    // data passes through the same depth as the clock, so it is aligned
    assign bit_stb = mdc_sr[STAGES-1] & ~mdc_last;
    assign bit_val = mdio_sr[STAGES-1];

endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
    import mdio_slave_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic [PHY_AW-1:0] port_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [REG_AW-1:0] reg_addr,
    output logic              mdio_o,
    output logic              mdio_oe,
    output bank_wr_t          wr,
    output evt_t              evt
);

    localparam int PRE_W  = $clog2(PRE_LEN + 1);
    localparam int LONGEST = (DATA_W > ADDR_BITS) ? DATA_W : ADDR_BITS;
    localparam int CNT_W  = $clog2(LONGEST);
    localparam logic [PRE_W-1:0] PRE_FULL  = PRE_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    frame_state_t          state;
    logic [PRE_W-1:0]      pre_cnt;
    logic [CNT_W-1:0]      bcnt;
    logic [1:0]            opc;
    logic [ADDR_BITS-1:0]  addr_sh;
    logic [DATA_W-1:0]     data_sh;
    logic [REG_AW-1:0]     reg_q;

    logic                  is_read;
    logic [ADDR_BITS-1:0]  addr_nxt;
    logic [DATA_W-1:0]     data_nxt;

    assign is_read  = (opc == OPC_READ);
    assign addr_nxt = {addr_sh[ADDR_BITS-2:0], bit_val};
    assign data_nxt = {data_sh[DATA_W-2:0], bit_val};
    assign reg_addr = reg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pre_cnt <= '0;
            bcnt    <= '0;
            opc     <= '0;
            addr_sh <= '0;
            data_sh <= '0;
            reg_q   <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            wr      <= '0;
            evt     <= '0;
        end else begin
            evt   <= '0;
            wr.we <= 1'b0;
            if (bit_stb) begin
                case (state)
                    ST_IDLE: begin
                        if (bit_val) begin
                            if (pre_cnt != PRE_FULL)
                                pre_cnt <= pre_cnt + 1'b1;
                        end else begin
                            if (pre_cnt == PRE_FULL)
                                state <= ST_START;
                            pre_cnt <= '0;
                        end
                    end
                    ST_START: begin
                        bcnt <= '0;
                        if (bit_val) begin
                            state <= ST_OPC;
                        end else begin
                            evt.err <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end
                    ST_OPC: begin
                        opc  <= {opc[0], bit_val};
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == OPC_LAST) begin
                            bcnt  <= '0;
                            state <= ST_ADDR;
                        end
                    end
                    ST_ADDR: begin
                        addr_sh <= addr_nxt;
                        bcnt    <= bcnt + 1'b1;
                        if (bcnt == ADDR_LAST) begin
                            bcnt  <= '0;
                            reg_q <= addr_nxt[REG_AW-1:0];
                            if (addr_nxt[ADDR_BITS-1 -: PHY_AW] != port_addr) begin
                                state <= ST_IDLE;
                            end else if (!opc_valid(opc)) begin
                                evt.err <= 1'b1;
                                state   <= ST_IDLE;
                            end else begin
                                state <= ST_TA1;
                            end
                        end
                    end
                    ST_TA1: begin
                        if (is_read) begin
                            mdio_oe <= 1'b1;
                            mdio_o  <= 1'b0;
                            data_sh <= rd_data;
                            state   <= ST_TA2;
                        end else if (!bit_val) begin
                            evt.err <= 1'b1;
                            state   <= ST_IDLE;
                        end else begin
                            state <= ST_TA2;
                        end
                    end
                    ST_TA2: begin
                        bcnt <= '0;
                        if (is_read) begin
                            mdio_o  <= data_sh[DATA_W-1];
                            data_sh <= {data_sh[DATA_W-2:0], 1'b0};
                            state   <= ST_DATA;
                        end else if (bit_val) begin
                            evt.err <= 1'b1;
                            state   <= ST_IDLE;
                        end else begin
                            state <= ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        bcnt <= bcnt + 1'b1;
                        if (is_read) begin
                            mdio_o  <= data_sh[DATA_W-1];
                            data_sh <= {data_sh[DATA_W-2:0], 1'b0};
                            if (bcnt == DATA_LAST) begin
                                mdio_oe <= 1'b0;
                                mdio_o  <= 1'b0;
                                evt.rd  <= 1'b1;
                                state   <= ST_IDLE;
                            end
                        end else begin
                            data_sh <= data_nxt;
                            if (bcnt == DATA_LAST) begin
                                wr.we   <= 1'b1;
                                wr.addr <= reg_q;
                                wr.data <= data_nxt;
                                evt.wr  <= 1'b1;
                                state   <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_QUIET_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !mdio_oe); // R11

    AST_TA_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> !mdio_o); // R3

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.err, evt.rd, evt.wr})); // R7

    AST_NO_STORE_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        evt.err |-> !wr.we); // R7

endmodule

// File: rtl/mdio_reg_banks.sv
`timescale 1ns/1ps
module mdio_reg_banks
    import mdio_slave_pkg::*;
#(
    parameter int NUM_REGS = 1 << REG_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_wr_t          mdio_wr,
    input  logic              loc_we,
    input  logic [REG_AW-1:0] loc_waddr,
    input  logic [DATA_W-1:0] loc_wdata,
    input  logic [REG_AW-1:0] loc_raddr,
    output logic [DATA_W-1:0] loc_rdata,
    input  logic [REG_AW-1:0] mdio_raddr,
    output logic [DATA_W-1:0] mdio_rdata
);

    logic [DATA_W-1:0] in_vec  [NUM_REGS];
    logic [DATA_W-1:0] out_vec [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
        logic [DATA_W-1:0] in_r;
        logic [DATA_W-1:0] out_r;

        always_ff @(posedge clk) begin
            if (rst)
                in_r <= '0;
            else if (mdio_wr.we && (mdio_wr.addr == REG_AW'(i)))
                in_r <= mdio_wr.data;
        end

        always_ff @(posedge clk) begin
            if (rst)
                out_r <= '0;
            else if (loc_we && (loc_waddr == REG_AW'(i)))
                out_r <= loc_wdata;
        end

        assign in_vec[i]  = in_r;
        assign out_vec[i] = out_r;
    end

    assign loc_rdata  = in_vec[loc_raddr];
    assign mdio_rdata = out_vec[mdio_raddr];

    AST_IN_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mdio_wr.we ##1 $stable(loc_raddr)) |-> $stable(loc_rdata)); // R2

    AST_OUT_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!loc_we ##1 $stable(mdio_raddr)) |-> $stable(mdio_rdata)); // R3

endmodule

// File: rtl/mdio_event_ctrl.sv
`timescale 1ns/1ps
module mdio_event_ctrl #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] flags,
    output logic         irq
);

    logic [N-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (set[i])
                    flag_q[i] <= 1'b1;
                else if (clr[i])
                    flag_q[i] <= 1'b0;
            end
        end
    end

    assign flags = flag_q;
    assign irq   = |(flag_q & en);

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !clr[i]) |=> flags[i]); // R8
    end

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|flags)); // R9

endmodule

// File: rtl/mdio_slave_regs.sv
`timescale 1ns/1ps
module mdio_slave_regs
    import mdio_slave_pkg::*;
#(
    parameter int NUM_REGS    = 1 << REG_AW,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mdc_i,
    input  logic               mdio_i,
    output logic               mdio_o,
    output logic               mdio_oe,
    input  logic [PHY_AW-1:0]  port_addr,
    input  logic               loc_we,
    input  logic [REG_AW-1:0]  loc_waddr,
    input  logic [DATA_W-1:0]  loc_wdata,
    input  logic [REG_AW-1:0]  loc_raddr,
    output logic [DATA_W-1:0]  loc_rdata,
    input  logic [NUM_EVT-1:0] evt_en,
    input  logic [NUM_EVT-1:0] evt_clr,
    output logic [NUM_EVT-1:0] evt_flags,
    output logic               irq
);

    logic              bit_stb;
    logic              bit_val;
    logic [REG_AW-1:0] fsm_raddr;
    logic [DATA_W-1:0] fsm_rdata;
    bank_wr_t          fsm_wr;
    evt_t              fsm_evt;

    mdio_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .mdc_i   (mdc_i),
        .mdio_i  (mdio_i),
        .bit_stb (bit_stb),
        .bit_val (bit_val)
    );

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .port_addr (port_addr),
        .rd_data   (fsm_rdata),
        .reg_addr  (fsm_raddr),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .wr        (fsm_wr),
        .evt       (fsm_evt)
    );

    mdio_reg_banks #(
        .NUM_REGS (NUM_REGS)
    ) u_banks (
        .clk        (clk),
        .rst        (rst),
        .mdio_wr    (fsm_wr),
        .loc_we     (loc_we),
        .loc_waddr  (loc_waddr),
        .loc_wdata  (loc_wdata),
        .loc_raddr  (loc_raddr),
        .loc_rdata  (loc_rdata),
        .mdio_raddr (fsm_raddr),
        .mdio_rdata (fsm_rdata)
    );

    mdio_event_ctrl #(
        .N (NUM_EVT)
    ) u_evt (
        .clk   (clk),
        .rst   (rst),
        .set   ({fsm_evt.err, fsm_evt.rd, fsm_evt.wr}),
        .clr   (evt_clr),
        .en    (evt_en),
        .flags (evt_flags),
        .irq   (irq)
    );

    AST_READ_FLAG_AFTER_DRIVE: assert property (@(posedge clk) disable iff (rst)
        $fell(mdio_oe) |=> evt_flags[1]); // R6

endmodule

// File: tb/mdio_slave_regs_test.sv
`timescale 1ns/1ps
module mdio_slave_regs_test;
    import mdio_slave_pkg::*;

    localparam int HALF = 6;
    localparam logic [4:0] PORT_A = 5'h0B;
    localparam logic [4:0] PORT_B = 5'h14;

    logic        clk = 1'b0;
    logic        rst;
    logic        mdc;
    logic        m_en;
    logic        m_bit;
    logic        mdio_line;
    logic        mdio_o;
    logic        mdio_oe;
    logic [4:0]  port_addr;
    logic        loc_we;
    logic [4:0]  loc_waddr;
    logic [15:0] loc_wdata;
    logic [4:0]  loc_raddr;
    logic [15:0] loc_rdata;
    logic [2:0]  evt_en;
    logic [2:0]  evt_clr;
    logic [2:0]  evt_flags;
    logic        irq;

    always #2.5 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : (m_en ? m_bit : 1'b1);

    mdio_slave_regs uut (
        .clk       (clk),
        .rst       (rst),
        .mdc_i     (mdc),
        .mdio_i    (mdio_line),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .port_addr (port_addr),
        .loc_we    (loc_we),
        .loc_waddr (loc_waddr),
        .loc_wdata (loc_wdata),
        .loc_raddr (loc_raddr),
        .loc_rdata (loc_rdata),
        .evt_en    (evt_en),
        .evt_clr   (evt_clr),
        .evt_flags (evt_flags),
        .irq       (irq)
    );

    int          total = 0;
    int          bad   = 0;
    logic        done  = 1'b0;
    logic [15:0] exp_in [32];

    logic        s_oe, s_val;
    logic        oe_hdr, ta1_oe, ta2_oe, ta2_val;
    int          data_oe;
    logic [15:0] got;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] wpat(input int r);
        return 16'(r * 7919) ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] rpat(input int r);
        return 16'(r * 40503) ^ 16'h3C69;
    endfunction

    task automatic mbit(input logic drv, input logic b);
        mdc   = 1'b0;
        m_en  = drv;
        m_bit = b;
        repeat (HALF) @(negedge clk);
        s_oe  = mdio_oe;
        s_val = mdio_line;
        mdc   = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] phy, input logic [4:0] ra, input logic rd,
                         input logic [1:0] ta, input logic [15:0] wd);
        logic [13:0] hdr;
        hdr     = {st, op, phy, ra};
        oe_hdr  = 1'b0;
        data_oe = 0;
        got     = '0;
        for (int i = 0; i < pre; i++) begin
            mbit(1'b1, 1'b1);
            oe_hdr |= s_oe;
        end
        for (int i = 13; i >= 0; i--) begin
            mbit(1'b1, hdr[i]);
            oe_hdr |= s_oe;
        end
        if (rd) begin
            mbit(1'b0, 1'b1); ta1_oe = s_oe;
            mbit(1'b0, 1'b1); ta2_oe = s_oe; ta2_val = s_val;
            for (int i = 15; i >= 0; i--) begin
                mbit(1'b0, 1'b1);
                got[i] = s_val;
                if (s_oe) data_oe++;
            end
        end else begin
            mbit(1'b1, ta[1]); ta1_oe = s_oe;
            mbit(1'b1, ta[0]); ta2_oe = s_oe; ta2_val = s_val;
            for (int i = 15; i >= 0; i--) begin
                mbit(1'b1, wd[i]);
                if (s_oe) data_oe++;
            end
        end
        mbit(1'b0, 1'b1);
        mbit(1'b0, 1'b1);
    endtask

    task automatic clear(input logic [2:0] bits);
        @(negedge clk) evt_clr = bits;
        @(negedge clk) evt_clr = 3'b000;
        @(negedge clk);
    endtask

    task automatic lwrite(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        loc_we = 1'b1; loc_waddr = a; loc_wdata = d;
        @(negedge clk);
        loc_we = 1'b0;
    endtask

    task automatic check_in_bank(input string tag);
        for (int r = 0; r < 32; r++) begin
            loc_raddr = 5'(r);
            @(negedge clk);
            chk($sformatf("%s input reg %0d", tag, r), loc_rdata, exp_in[r]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mdc = 1'b0; m_en = 1'b0; m_bit = 1'b1;
        port_addr = PORT_A; loc_we = 1'b0; loc_waddr = '0; loc_wdata = '0;
        loc_raddr = '0; evt_en = 3'b000; evt_clr = 3'b000;
        for (int r = 0; r < 32; r++) exp_in[r] = 16'h0000;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1 flags", evt_flags, 3'b000);
        chk("R1 irq", irq, 1'b0);
        chk("R1 mdio_oe", mdio_oe, 1'b0);
        check_in_bank("R1");

        // R2 R5 R8 R11: write to every register
        for (int r = 0; r < 32; r++) begin
            frame(32, 2'b01, OPC_WRITE, PORT_A, 5'(r), 1'b0, 2'b10, wpat(r));
            exp_in[r] = wpat(r);
            loc_raddr = 5'(r);
            @(negedge clk);
            chk($sformatf("R2 write reg %0d", r), loc_rdata, exp_in[r]);
            chk("R5 write flag", evt_flags, 3'b001);
            chk("R11 no drive on write", {oe_hdr, ta1_oe, ta2_oe, 5'(data_oe)}, 8'h00);
            clear(3'b001);
            chk("R8 flag cleared", evt_flags, 3'b000);
        end
        check_in_bank("R2");

        // R3 R6: read every output register
        for (int r = 0; r < 32; r++) lwrite(5'(r), rpat(r));
        for (int r = 0; r < 32; r++) begin
            frame(32, 2'b01, OPC_READ, PORT_A, 5'(r), 1'b1, 2'b00, 16'h0000);
            chk("R3 released on first turnaround", ta1_oe, 1'b0);
            chk("R3 driven zero on second turnaround", {ta2_oe, ta2_val}, 2'b10);
            chk("R3 drive during data", data_oe, 16);
            chk($sformatf("R3 read reg %0d", r), got, rpat(r));
            chk("R11 no drive in header", oe_hdr, 1'b0);
            chk("R6 read flag", evt_flags, 3'b010);
            clear(3'b010);
        end
        check_in_bank("R3 reads leave inputs");

        // R4: every other port address is ignored
        for (int p = 0; p < 32; p++) begin
            if (5'(p) != PORT_A) begin
                if (p % 2 == 1)
                    frame(32, 2'b01, OPC_WRITE, 5'(p), 5'(p), 1'b0, 2'b10, ~wpat(p));
                else
                    frame(32, 2'b01, OPC_READ, 5'(p), 5'(p), 1'b1, 2'b00, 16'h0000);
                loc_raddr = 5'(p);
                @(negedge clk);
                chk($sformatf("R4 reg %0d kept for port %0d", p, p), loc_rdata, exp_in[p]);
                chk("R4 no event", evt_flags, 3'b000);
                chk("R4 no drive", {oe_hdr, ta1_oe, ta2_oe, 5'(data_oe)}, 8'h00);
            end
        end
        port_addr = PORT_B;
        frame(32, 2'b01, OPC_WRITE, PORT_B, 5'd7, 1'b0, 2'b10, 16'h1234);
        exp_in[7] = 16'h1234;
        frame(32, 2'b01, OPC_WRITE, PORT_A, 5'd8, 1'b0, 2'b10, 16'h4321);
        check_in_bank("R4 new port");
        chk("R4 new port event", evt_flags, 3'b001);
        clear(3'b111);

        // R10: short preamble
        mbit(1'b1, 1'b0);
        frame(31, 2'b01, OPC_WRITE, PORT_B, 5'd9, 1'b0, 2'b10, 16'h0F0F);
        loc_raddr = 5'd9;
        @(negedge clk);
        chk("R10 short preamble reg", loc_rdata, exp_in[9]);
        chk("R10 short preamble event", evt_flags, 3'b000);
        mbit(1'b1, 1'b0);
        frame(31, 2'b01, OPC_READ, PORT_B, 5'd9, 1'b1, 2'b00, 16'h0000);
        chk("R10 short preamble drive", {oe_hdr, ta1_oe, ta2_oe, 5'(data_oe)}, 8'h00);
        chk("R10 short preamble read event", evt_flags, 3'b000);

        // R7: malformed frames
        frame(32, 2'b00, OPC_WRITE, PORT_B, 5'd4, 1'b0, 2'b10, 16'h0000);
        chk("R7 bad start", evt_flags, 3'b100);
        clear(3'b100);
        frame(32, 2'b01, 2'b00, PORT_B, 5'd5, 1'b0, 2'b10, 16'h0000);
        chk("R7 opcode 00", evt_flags, 3'b100);
        clear(3'b100);
        frame(32, 2'b01, 2'b11, PORT_B, 5'd6, 1'b0, 2'b10, 16'hFFFF);
        chk("R7 opcode 11", evt_flags, 3'b100);
        clear(3'b100);
        frame(32, 2'b01, 2'b11, PORT_B ^ 5'h01, 5'd6, 1'b0, 2'b10, 16'h0000);
        chk("R4 bad opcode elsewhere", evt_flags, 3'b000);
        frame(32, 2'b01, OPC_WRITE, PORT_B, 5'd8, 1'b0, 2'b11, 16'hC3C3);
        chk("R7 write turnaround 11", evt_flags, 3'b100);
        clear(3'b100);
        frame(32, 2'b01, OPC_WRITE, PORT_B, 5'd8, 1'b0, 2'b00, 16'hC3C3);
        chk("R7 write turnaround 00", evt_flags, 3'b100);
        chk("R11 no drive on errors", oe_hdr, 1'b0);
        clear(3'b100);
        check_in_bank("R7 discarded");

        // R9 R8: enables against flag sets
        frame(32, 2'b01, OPC_WRITE, PORT_B, 5'd10, 1'b0, 2'b10, 16'hBEEF);
        exp_in[10] = 16'hBEEF;
        frame(32, 2'b01, OPC_READ, PORT_B, 5'd10, 1'b1, 2'b00, 16'h0000);
        frame(32, 2'b01, 2'b00, PORT_B, 5'd11, 1'b0, 2'b10, 16'h0000);
        chk("R8 flags accumulate", evt_flags, 3'b111);
        for (int m = 0; m < 8; m++) begin
            evt_en = 3'(m);
            @(negedge clk);
            chk($sformatf("R9 irq all flags en=%0d", m), irq, (m != 0));
        end
        clear(3'b001);
        chk("R8 selective clear", evt_flags, 3'b110);
        for (int m = 0; m < 8; m++) begin
            evt_en = 3'(m);
            @(negedge clk);
            chk($sformatf("R9 irq flags 110 en=%0d", m), irq, ((m & 6) != 0));
        end
        clear(3'b110);
        evt_en = 3'b111;
        @(negedge clk);
        chk("R8 all cleared", evt_flags, 3'b000);
        chk("R9 irq low with no flags", irq, 1'b0);
        check_in_bank("R2 final");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule